// File: doc/BRIEF.md
# Holdover-Capable Numerically Controlled Oscillator

This block is the frequency-synthesis core of a timing recovery path. A phase accumulator is clocked by the 20 MHz master clock. On every master clock edge it adds an applied frequency word. The accumulator's top bit is the synthesized clock, and all downstream dividers derive from that clock, so they stay locked to one another whatever the mode. The applied word is a fixed nominal centre value plus a signed correction. While tracking, the correction comes live from an external loop filter. In holdover it comes from a stored history. In freerun it is zero.

The history is the defining feature. While tracking, a sample timer runs. Each time it completes an interval (30 ms, 600,000 master cycles, by default) the live correction is shifted into a two-deep history. Holdover replays the older of the two entries, so the replayed value is always between one and two intervals old. Corrections disturbed by a failing reference just before holdover was entered therefore never reach the output. The history and its timer are frozen outside tracking mode, so entering holdover again reuses the same trusted value.

Top module: `nco_holdover_osc`

## Requirements
- R1: `mode_i` selects the mode: 2'b00 tracking, 2'b01 holdover, 2'b10 freerun. The code 2'b11 also means freerun.
- R2: In tracking mode, `freq_word_o` equals NOM_WORD plus the sign-extended `corr_i` in the same cycle. It changes as soon as the inputs change, with no clock edge needed.
- R3: In freerun mode, `freq_word_o` equals NOM_WORD whatever the value of `corr_i`.
- R4: The sum of NOM_WORD and the selected correction is clamped to the range 0 to 2^ACC_W-1. A negative sum gives 0, and a sum above the range gives all ones.
- R5: Every SAMPLE_CYCLES edges spent in tracking mode, the live `corr_i` is shifted into a two-entry history. In holdover, `freq_word_o` equals NOM_WORD plus the older entry.
- R6: Outside tracking mode the sample timer and the history hold their values. Edges spent in holdover or freerun neither advance the sample timer nor change the history.
- R7: Until two samples have been captured since reset, holdover applies NOM_WORD.
- R8: On every edge outside reset, the accumulator advances by `freq_word_o` modulo 2^ACC_W. `clk_o` is the accumulator's most significant bit.
- R9: `wrap_o` is high for the single cycle that follows an edge on which the addition carried out of the accumulator, and low otherwise.
- R10: A mode change does not reset the accumulator. The next edge adds the new word to the current phase.
- R11: While `rst_n` is low on an edge, the accumulator, `wrap_o`, the history, its fill count and the sample timer are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Operating mode select (R1) |
| corr_i | input | CORR_W | Signed correction word from the loop filter |
| clk_o | output | 1 | Synthesized clock, the accumulator MSB |
| wrap_o | output | 1 | One-cycle accumulator overflow strobe |
| freq_word_o | output | ACC_W | Frequency word applied in this cycle |

## Verification
Two functions can meet on the same edge: a history capture and a switch into holdover. The bench lets the sample timer reach the last cycle of its interval and then moves to holdover in the very next cycle. It judges the result by whether the replayed word is the entry that the capture just pushed to the older slot. To reach that point, the timer is first advanced partly, then parked across a long holdover stretch and finished with a counted number of tracking edges. This exposes any timer that leaks outside tracking mode. Phase continuity is judged separately: a mode change is made mid-cycle of the synthesized clock, and the following accumulator values and the wrap strobe are checked.

// File: rtl/nco_pkg.sv
// Package: shared mode encoding for the holdover oscillator.
// Assumes a two-bit mode select where the top code aliases freerun.
package nco_pkg;
    typedef enum logic [1:0] {
        MODE_TRACK    = 2'b00,
        MODE_HOLD     = 2'b01,
        MODE_FREE     = 2'b10,
        MODE_FREE_ALT = 2'b11
    } osc_mode_e;
endpackage

// File: rtl/nco_history.sv
// Module: correction history with interval timer.
// While cap_en_i is high, a timer counts edges. On the last edge of each
// SAMPLE_CYCLES interval, corr_i is shifted into a HIST_DEPTH-deep history.
// The oldest entry is offered for holdover once the history is full.
// Assumes cap_en_i is high only in tracking mode; otherwise everything holds.
module nco_history #(
    parameter int CORR_W        = 24,
    parameter int HIST_DEPTH    = 2,
    parameter int SAMPLE_CYCLES = 600000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cap_en_i,
    input  logic signed [CORR_W-1:0] corr_i,
    output logic signed [CORR_W-1:0] old_corr_o,
    output logic                     old_valid_o
);
    localparam int TMR_W  = $clog2(SAMPLE_CYCLES + 1);
    localparam int FILL_W = $clog2(HIST_DEPTH + 1);
    localparam logic [TMR_W-1:0]  TMR_LAST  = TMR_W'(SAMPLE_CYCLES - 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(HIST_DEPTH);

    logic [TMR_W-1:0]         tmr_q;
    logic [FILL_W-1:0]        fill_q;
    logic signed [CORR_W-1:0] hist_q [HIST_DEPTH];
    logic                     sample_now;

    // Purpose: a sample is taken on the last tracking edge of an interval.
    assign sample_now = cap_en_i && (tmr_q == TMR_LAST);

    // Purpose: interval timer, frozen outside tracking mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmr_q <= '0;
        else if (sample_now)
            tmr_q <= '0;
        else if (cap_en_i)
            tmr_q <= tmr_q + 1'b1;
    end

    // Purpose: count captured samples up to the history depth.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= '0;
        else if (sample_now && (fill_q != FILL_FULL))
            fill_q <= fill_q + 1'b1;
    end

    // Purpose: newest entry takes the live correction on a sample edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist_q[0] <= '0;
        else if (sample_now)
            hist_q[0] <= corr_i;
    end

    // Purpose: older entries shift one place on each sample edge.
    for (genvar g = 1; g < HIST_DEPTH; g++) begin : g_shift
        always_ff @(posedge clk) begin
            if (!rst_n)
                hist_q[g] <= '0;
            else if (sample_now)
                hist_q[g] <= hist_q[g-1];
        end
    end

    assign old_corr_o  = hist_q[HIST_DEPTH-1];
    assign old_valid_o = (fill_q == FILL_FULL);
endmodule

// File: rtl/nco_word_sel.sv
// Module: applied frequency word selection and clamping.
// Picks the live, stored or zero correction by mode, adds it to the nominal
// centre word and clamps the sum to the legal unsigned word range.
// Purely combinational; assumes CORR_W <= ACC_W + 1.
module nco_word_sel
    import nco_pkg::*;
#(
    parameter int          ACC_W    = 32,
    parameter int          CORR_W   = 24,
    parameter logic [ACC_W-1:0] NOM_WORD = 32'hD1B7_1759
) (
    input  osc_mode_e                mode_i,
    input  logic signed [CORR_W-1:0] live_corr_i,
    input  logic signed [CORR_W-1:0] old_corr_i,
    input  logic                     old_valid_i,
    output logic [ACC_W-1:0]         word_o
);
    localparam int SUM_W = ACC_W + 2;

    logic signed [CORR_W-1:0] corr_sel;
    logic signed [SUM_W-1:0]  corr_ext;
    logic signed [SUM_W-1:0]  sum;

    // Purpose: choose the correction source for the current mode.
    always_comb begin
        unique case (mode_i)
            MODE_TRACK: corr_sel = live_corr_i;
            MODE_HOLD:  corr_sel = old_valid_i ? old_corr_i : '0;
            default:    corr_sel = '0;
        endcase
    end

    // Purpose: add to the centre word and clamp to 0 .. 2^ACC_W-1.
    always_comb begin
        corr_ext = {{(SUM_W-CORR_W){corr_sel[CORR_W-1]}}, corr_sel};
        sum      = $signed({2'b00, NOM_WORD}) + corr_ext;
        if (sum[SUM_W-1])
            word_o = '0;
        else if (sum[ACC_W])
            word_o = '1;
        else
            word_o = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/nco_phase_acc.sv
// Module: phase accumulator.
// Adds the applied word on every master edge, wrapping modulo 2^ACC_W.
// Registers the carry as a one-cycle strobe. The MSB is the output clock.
// Assumes the word is valid every cycle; it is never reset by a mode change.
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] word_i,
    output logic             msb_o,
    output logic             carry_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   acc_next;

    // Purpose: widened sum exposes the carry out of the accumulator.
    assign acc_next = {1'b0, acc_q} + {1'b0, word_i};

    // Purpose: advance the phase and register the wrap strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            carry_o <= 1'b0;
        end else begin
            acc_q   <= acc_next[ACC_W-1:0];
            carry_o <= acc_next[ACC_W];
        end
    end

    assign msb_o = acc_q[ACC_W-1];
endmodule

// File: rtl/nco_holdover_osc.sv
// Module: holdover-capable numerically controlled oscillator (top).
// Tracking applies the live correction, holdover replays the older history
// entry, and freerun applies the centre word. The accumulator runs on
// unchanged across mode changes. Assumes a synchronous active-low reset.
module nco_holdover_osc
    import nco_pkg::*;
#(
    parameter int          ACC_W         = 32,
    parameter int          CORR_W        = 24,
    parameter int          SAMPLE_CYCLES = 600000,
    parameter logic [ACC_W-1:0] NOM_WORD = 32'hD1B7_1759
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic signed [CORR_W-1:0] corr_i,
    output logic                     clk_o,
    output logic                     wrap_o,
    output logic [ACC_W-1:0]         freq_word_o
);
    localparam int HIST_DEPTH = 2;

    osc_mode_e                mode;
    logic signed [CORR_W-1:0] old_corr;
    logic                     old_valid;

    // Purpose: decode the raw mode pins into the shared enum.
    assign mode = osc_mode_e'(mode_i);

    nco_history #(
        .CORR_W       (CORR_W),
        .HIST_DEPTH   (HIST_DEPTH),
        .SAMPLE_CYCLES(SAMPLE_CYCLES)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (mode == MODE_TRACK),
        .corr_i     (corr_i),
        .old_corr_o (old_corr),
        .old_valid_o(old_valid)
    );

    nco_word_sel #(
        .ACC_W   (ACC_W),
        .CORR_W  (CORR_W),
        .NOM_WORD(NOM_WORD)
    ) u_sel (
        .mode_i     (mode),
        .live_corr_i(corr_i),
        .old_corr_i (old_corr),
        .old_valid_i(old_valid),
        .word_o     (freq_word_o)
    );

    nco_phase_acc #(
        .ACC_W(ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (freq_word_o),
        .msb_o  (clk_o),
        .carry_o(wrap_o)
    );
endmodule

// File: rtl/nco_holdover_chk.sv
// Module: assertion checker bound to the oscillator top.
// Relates the accumulator phase to the applied word and the wrap strobe,
// and checks mode behaviour at the ports. Assumes reset is low at time zero.
module nco_holdover_chk #(
    parameter int          ACC_W    = 32,
    parameter int          CORR_W   = 24,
    parameter logic [ACC_W-1:0] NOM_WORD = 32'hD1B7_1759
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [CORR_W-1:0] corr_i,
    input logic              wrap_o,
    input logic [ACC_W-1:0]  freq_word_o,
    input logic [ACC_W-1:0]  acc_q
);
    logic past_ok = 1'b0;

    // Purpose: mark that at least one edge has been seen.
    always_ff @(posedge clk) past_ok <= 1'b1;

    // R8: phase advances by exactly the previously applied word
    assert_phase_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n)) |-> (acc_q == $past(acc_q) + $past(freq_word_o)));

    // R9: strobe is high exactly when the phase went backwards (a wrap)
    assert_wrap_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n)) |-> (wrap_o == (acc_q < $past(acc_q))));

    // R3: freerun codes apply the centre word
    assert_free_centre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |-> (freq_word_o == NOM_WORD));

    // R6: the replayed word cannot move while holdover persists
    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n) && mode_i == 2'b01 && $past(mode_i) == 2'b01)
        |-> $stable(freq_word_o));

    // R2: with a steady correction, tracking holds a steady word
    assert_track_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rst_n) && mode_i == 2'b00 && $past(mode_i) == 2'b00
         && $stable(corr_i)) |-> $stable(freq_word_o));

    // R11: a reset edge leaves phase and strobe cleared
    assert_reset_clear_R11: assert property (@(posedge clk)
        (past_ok && !$past(rst_n)) |-> (acc_q == '0 && !wrap_o));
endmodule

bind nco_holdover_osc nco_holdover_chk #(
    .ACC_W   (ACC_W),
    .CORR_W  (CORR_W),
    .NOM_WORD(NOM_WORD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .corr_i     (corr_i),
    .wrap_o     (wrap_o),
    .freq_word_o(freq_word_o),
    .acc_q      (u_acc.acc_q)
);

// File: tb/nco_holdover_osc_tb_top.sv
// Bench: self-checking test of the holdover oscillator.
// Three instances share the inputs and differ only in the centre word, so
// that both clamp limits can be reached (R4).
module nco_holdover_osc_tb_top;
    localparam int          ACC_W  = 32;
    localparam int          CORR_W = 32;
    localparam int          SAMP   = 8;
    localparam logic [31:0] NOM    = 32'h4000_0000;
    localparam logic [31:0] NOM_HI = 32'hF000_0000;
    localparam logic [31:0] NOM_LO = 32'h1000_0000;
    localparam logic [31:0] C1 = 32'h0000_1234;
    localparam logic [31:0] C2 = 32'hFFFF_FF00;
    localparam logic [31:0] C4 = 32'h0000_0010;
    localparam logic [31:0] C5 = 32'h0000_0055;
    localparam logic [31:0] CX = 32'h0BAD_0000;

    typedef struct packed {
        logic [1:0]  mode;
        logic [31:0] corr;
        logic [31:0] exp_mid;
        logic [31:0] exp_hi;
        logic [31:0] exp_lo;
    } vec_t;

    // Applied with C2 as the older history entry (R1 R2 R3 R4 R5)
    localparam vec_t VECS [8] = '{
        '{2'b00, 32'h7FFF_FFFF, 32'hBFFF_FFFF, 32'hFFFF_FFFF, 32'h8FFF_FFFF},
        '{2'b00, 32'h8000_0000, 32'h0000_0000, 32'h7000_0000, 32'h0000_0000},
        '{2'b01, 32'h7FFF_FFFF, 32'h3FFF_FF00, 32'hEFFF_FF00, 32'h0FFF_FF00},
        '{2'b10, 32'h1234_5678, 32'h4000_0000, 32'hF000_0000, 32'h1000_0000},
        '{2'b11, 32'h1234_5678, 32'h4000_0000, 32'hF000_0000, 32'h1000_0000},
        '{2'b00, 32'h0000_0000, 32'h4000_0000, 32'hF000_0000, 32'h1000_0000},
        '{2'b00, 32'h1000_0000, 32'h5000_0000, 32'hFFFF_FFFF, 32'h2000_0000},
        '{2'b01, 32'h0000_0000, 32'h3FFF_FF00, 32'hEFFF_FF00, 32'h0FFF_FF00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode = 2'b10;
    logic [31:0] corr = '0;
    logic        clk_o, wrap_o, clk_hi, wrap_hi, clk_lo, wrap_lo;
    logic [31:0] word, word_hi, word_lo;
    int          n_chk = 0;
    int          n_err = 0;
    int          cyc = 0;

    always #2 clk = ~clk;

    nco_holdover_osc #(.ACC_W(ACC_W), .CORR_W(CORR_W), .SAMPLE_CYCLES(SAMP),
        .NOM_WORD(NOM)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .corr_i(corr),
        .clk_o(clk_o), .wrap_o(wrap_o), .freq_word_o(word));

    nco_holdover_osc #(.ACC_W(ACC_W), .CORR_W(CORR_W), .SAMPLE_CYCLES(SAMP),
        .NOM_WORD(NOM_HI)) dut_hi (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .corr_i(corr),
        .clk_o(clk_hi), .wrap_o(wrap_hi), .freq_word_o(word_hi));

    nco_holdover_osc #(.ACC_W(ACC_W), .CORR_W(CORR_W), .SAMPLE_CYCLES(SAMP),
        .NOM_WORD(NOM_LO)) dut_lo (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .corr_i(corr),
        .clk_o(clk_lo), .wrap_o(wrap_lo), .freq_word_o(word_lo));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        // Phase A: accumulator, strobe, continuity (freerun, centre 1/4 turn)
        mode = 2'b10; corr = 32'h0;
        do_reset();
        #1;
        chk("R11 clk_o after reset", {31'b0, clk_o}, 32'd0);
        chk("R11 wrap_o after reset", {31'b0, wrap_o}, 32'd0);
        chk("R3 freerun word", word, NOM);
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk); #1;
            chk("R8 clk_o is phase MSB", {31'b0, clk_o}, {31'b0, ((k % 4) >= 2)});
            chk("R9 wrap strobe", {31'b0, wrap_o}, {31'b0, ((k % 4) == 0)});
        end
        @(negedge clk);
        mode = 2'b00; corr = 32'h2000_0000;
        #1;
        chk("R2 tracking word live", word, 32'h6000_0000);
        chk("R8 phase half turn", {31'b0, clk_o}, 32'd1);
        @(negedge clk); #1;
        chk("R10 phase kept across mode change", {31'b0, clk_o}, 32'd1);
        chk("R10 no wrap yet", {31'b0, wrap_o}, 32'd0);
        @(negedge clk); #1;
        chk("R10 wrap after continued phase", {31'b0, wrap_o}, 32'd1);
        chk("R10 clk_o low after wrap", {31'b0, clk_o}, 32'd0);

        // Phase B: history capture, fallback, freeze
        mode = 2'b00; corr = C1;
        do_reset();
        repeat (SAMP) @(negedge clk);
        mode = 2'b01; corr = CX; #1;
        chk("R7 holdover with one sample uses centre", word, NOM);
        @(negedge clk);
        mode = 2'b00; corr = C2;
        repeat (SAMP) @(negedge clk);
        mode = 2'b01; corr = CX; #1;
        chk("R5 holdover replays older entry", word, NOM + C1);
        @(negedge clk);
        mode = 2'b10; #1;
        chk("R3 freerun ignores correction", word, NOM);
        @(negedge clk);
        mode = 2'b00; corr = C4; #1;
        chk("R2 tracking small correction", word, NOM + C4);
        repeat (3) @(negedge clk);
        mode = 2'b01; corr = CX;
        repeat (20) @(negedge clk);
        #1;
        chk("R6 history held through holdover", word, NOM + C1);
        mode = 2'b00; corr = C5;
        repeat (4) @(negedge clk);
        mode = 2'b01; #1;
        chk("R6 timer frozen outside tracking", word, NOM + C1);
        mode = 2'b00;
        @(negedge clk);
        mode = 2'b01; #1;
        chk("R5 capture then immediate holdover", word, NOM + C2);

        // Vector table: mode selection and clamping
        foreach (VECS[i]) begin
            @(negedge clk);
            mode = VECS[i].mode; corr = VECS[i].corr; #1;
            chk("R1 R4 word centre quarter", word, VECS[i].exp_mid);
            chk("R4 word high centre", word_hi, VECS[i].exp_hi);
            chk("R4 word low centre", word_lo, VECS[i].exp_lo);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule